// File: doc/BRIEF.md
# Conversion Trigger Select Unit

This block decides when a sampling converter starts converting its regular group. Software programs a single 32-bit control word that holds an enable bit, a self-clearing software start bit, a two-bit edge mode and a four-bit source number. The source number picks one of sixteen external event lines. The chosen line is brought into the clock domain through a synchronizer chain and then watched for rising edges, falling edges, both, or neither, depending on the edge mode.

A detected edge or a pending software request produces a one-clock start pulse toward the converter core, but only while the enable bit is set. The core answers with an acknowledge when conversion begins. That acknowledge clears the software start bit, and software can read the bit back to see whether its request is still outstanding. Changing the source number never fires a trigger by itself, even when the old line and the new line sit at different levels.

Top module: `trig_sel_unit`

## Requirements
- R1: After reset the control word reads 0x0000_0000 at byte offset 0x08, and `start_pulse` is 0. Any other address reads 0. Inside the word: enable is bit 0, edge mode is bits 29:28, source number is bits 27:24, software start is bit 30.
- R2: Writes to any bit outside bits 0, 24..30 are ignored, and those bits always read 0. This includes reserved bits 31 and 23.
- R3: Edge mode 00 never produces a pulse from an event line.
- R4: Edge mode 01 produces one pulse for each rising edge and none for a falling edge. The pulse is high in the third clock after the line changes (two synchronizer stages, then a registered output).
- R5: Edge mode 10 produces one pulse for each falling edge and none for a rising edge.
- R6: Edge mode 11 produces one pulse for each rising edge and one for each falling edge.
- R7: Source number n (0..15) makes only `ev_in[n]` able to trigger. Activity on every other line has no effect.
- R8: Writing a new source number gives no pulse, even when the newly chosen line is at a different level from the old one.
- R9: While enable is 0, no edge on the event lines produces a pulse.
- R10: A write that sets software start while the written enable bit is 0 is ignored: no pulse is produced and bit 30 reads 0. Writing enable 0 also drops a pending request.
- R11: A software start with enable 1 produces exactly one pulse. Bit 30 then reads 1 until `start_ack` is sampled high, and it reads 0 from the following cycle.
- R12: A software request and an event edge that fall in the same cycle merge into a single one-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address for register reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ev_in | input | 16 | Asynchronous external event lines |
| start_ack | input | 1 | Converter core reports that conversion has begun |
| start_pulse | output | 1 | One-clock start-of-conversion request |

## Verification
The hardest case to produce is a software request and an event edge that are recognised in the same cycle. The line change has to lead the register write by exactly one clock so that the synchronized edge and the newly set start bit arrive together. The stimulus creates this directly: it moves the selected line on one falling clock edge and places the control write on the next one, then counts the pulses. False edges on a source change are produced by parking two lines at opposite levels before the source number is switched. Random trials then sweep edge mode, source, enable and line activity, and compare the number of pulses against a model in the bench.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
   localparam int CTRL_W  = 32;
   localparam int EN_BIT  = 0;
   localparam int SEL_LSB = 24;
   localparam int POL_LSB = 28;
   localparam int SW_BIT  = 30;

   typedef enum logic [1:0] {
      POL_OFF  = 2'b00,
      POL_RISE = 2'b01,
      POL_FALL = 2'b10,
      POL_BOTH = 2'b11
   } pol_e;
endpackage

// File: rtl/tsu_ctrl_reg.sv
module tsu_ctrl_reg
   import tsu_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int CTRL_OFF = 8,
   parameter int SEL_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [CTRL_W-1:0]   bus_wdata,
   output logic [CTRL_W-1:0]   bus_rdata,
   input  logic                start_ack,
   output logic                en,
   output logic                sw_req,
   output logic [1:0]          pol,
   output logic [SEL_W-1:0]    sel
);
   localparam logic [ADDR_W-1:0] OFF = ADDR_W'(CTRL_OFF);

   logic hit;
   assign hit = (bus_addr == OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         sw_req <= 1'b0;
         pol    <= 2'b00;
         sel    <= '0;
      end else begin
         if (start_ack)
            sw_req <= 1'b0;
         if (bus_wr && hit) begin
            en  <= bus_wdata[EN_BIT];
            pol <= bus_wdata[POL_LSB +: 2];
            sel <= bus_wdata[SEL_LSB +: SEL_W];
            if (!bus_wdata[EN_BIT])
               sw_req <= 1'b0;
            else if (bus_wdata[SW_BIT])
               sw_req <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         bus_rdata[EN_BIT]              = en;
         bus_rdata[SW_BIT]              = sw_req;
         bus_rdata[POL_LSB +: 2]        = pol;
         bus_rdata[SEL_LSB +: SEL_W]    = sel;
      end
   end
endmodule

// File: rtl/tsu_edge_sel.sv
module tsu_edge_sel
   import tsu_pkg::*;
#(
   parameter int NUM_EV      = 16,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] ev_in,
   input  logic [SEL_W-1:0]  sel,
   input  logic [1:0]        pol,
   output logic              edge_hit
);
   logic [NUM_EV-1:0] synced;

   for (genvar i = 0; i < NUM_EV; i++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], ev_in[i]};
      end
      assign synced[i] = chain[SYNC_STAGES-1];
   end

   logic             cur, prev;
   logic [SEL_W-1:0] sel_q;
   logic             steady, rise, fall;
   pol_e             mode;

   assign cur    = synced[sel];
   assign steady = (sel == sel_q);
   assign rise   = cur & ~prev;
   assign fall   = ~cur & prev;
   assign mode   = pol_e'(pol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         sel_q <= '0;
      end else begin
         prev  <= cur;
         sel_q <= sel;
      end
   end

   always_comb begin
      unique case (mode)
         POL_RISE: edge_hit = steady & rise;
         POL_FALL: edge_hit = steady & fall;
         POL_BOTH: edge_hit = steady & (rise | fall);
         default:  edge_hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/tsu_start_gen.sv
module tsu_start_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sw_req,
   input  logic edge_hit,
   output logic start_pulse
);
   logic sw_issued, fire_sw;

   assign fire_sw = sw_req & ~sw_issued;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_issued   <= 1'b0;
         start_pulse <= 1'b0;
      end else begin
         sw_issued   <= sw_req ? (sw_issued | (en & fire_sw)) : 1'b0;
         start_pulse <= en & (edge_hit | fire_sw);
      end
   end
endmodule

// File: rtl/trig_sel_unit.sv
module trig_sel_unit
   import tsu_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CTRL_OFF    = 8,
   parameter int SEL_W       = 4,
   parameter int NUM_EV      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NUM_EV-1:0] ev_in,
   input  logic              start_ack,
   output logic              start_pulse
);
   if (NUM_EV != (1 << SEL_W)) begin : g_bad_num
      $error("NUM_EV must equal 2**SEL_W");
   end
   if (SEL_W > 4 || SEL_W < 1) begin : g_bad_sel
      $error("SEL_W must be 1..4 to fit its field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             en, sw_req, edge_hit;
   logic [1:0]       pol;
   logic [SEL_W-1:0] sel;

   tsu_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .SEL_W(SEL_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start_ack(start_ack),
      .en(en), .sw_req(sw_req), .pol(pol), .sel(sel)
   );

   tsu_edge_sel #(.NUM_EV(NUM_EV), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .sel(sel), .pol(pol),
      .edge_hit(edge_hit)
   );

   tsu_start_gen u_gen (
      .clk(clk), .rst_n(rst_n), .en(en), .sw_req(sw_req),
      .edge_hit(edge_hit), .start_pulse(start_pulse)
   );
endmodule

// File: rtl/tsu_chk.sv
module tsu_chk #(
   parameter int ADDR_W   = 8,
   parameter int CTRL_OFF = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              start_ack,
   input logic              start_pulse,
   input logic              en,
   input logic              sw_req,
   input logic [1:0]        pol
);
   logic set_wr;
   assign set_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_OFF)) && bus_wdata[0] && bus_wdata[30];

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[31] == 1'b0) && (bus_rdata[23] == 1'b0));

   // R9
   pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(en));

   // R3
   off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> ($past(sw_req) || ($past(pol) != 2'b00)));

   // R10
   sw_only_when_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req |-> en);

   // R11
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ack && !set_wr) |=> !sw_req);
endmodule

bind trig_sel_unit tsu_chk #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start_ack(start_ack),
   .start_pulse(start_pulse), .en(en), .sw_req(sw_req), .pol(pol)
);

// File: tb/sim_trig_sel_unit.sv
`timescale 1ns/1ps
module sim_trig_sel_unit;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [7:0]  bus_addr = 8'h08;
   logic        bus_wr = 0;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;
   logic [15:0] ev_in = 0;
   logic        start_ack = 0;
   logic        start_pulse;

   int errors = 0, checks = 0, pcnt = 0;
   bit done = 0;

   always #5 clk = ~clk;

   trig_sel_unit u0 (.*);

   always @(negedge clk) if (start_pulse) pcnt++;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] cw(bit sw, int pol, int sel, bit en);
      return (32'(sw) << 30) | (32'(pol) << 28) | (32'(sel) << 24) | 32'(en);
   endfunction

   function automatic int exp_cnt(bit en, int pol, bit o, bit n);
      if (!en || o == n) return 0;
      case (pol)
         1: return n ? 1 : 0;
         2: return n ? 0 : 1;
         3: return 1;
         default: return 0;
      endcase
   endfunction

   task automatic wr(logic [31:0] d);
      @(negedge clk); bus_addr = 8'h08; bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      @(negedge clk); bus_addr = a; #1 v = bus_rdata; bus_addr = 8'h08;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // configure, let sync settle, then toggle line and count pulses
   task automatic edge_trial(bit en, int pol, int sel, bit newv, logic [15:0] others, string tag);
      bit o;
      wr(cw(0, pol, sel, en));
      idle(5);
      pcnt = 0;
      o = ev_in[sel];
      ev_in = others;
      ev_in[sel] = newv;
      idle(6);
      chk(pcnt == exp_cnt(en, pol, o, newv), tag, pcnt, exp_cnt(en, pol, o, newv));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5EED));
      #22 rst_n = 1;

      // R1 reset state
      rd(8'h08, v); chk(v == 0, "R1 reset word", v, 0);
      chk(start_pulse == 0, "R1 reset pulse", start_pulse, 0);

      // R2 reserved bits ignored
      wr(32'hFFFF_FFFF & ~32'h4000_0000);
      rd(8'h08, v); chk(v == 32'h3F00_0001, "R2 writable mask", v, 32'h3F00_0001);
      rd(8'h04, v); chk(v == 0, "R1 other address", v, 0);
      wr(0); idle(4);

      // R4 latency: pulse in third clock after change
      wr(cw(0, 1, 2, 1)); idle(5); pcnt = 0;
      @(negedge clk); ev_in[2] = 1;
      @(negedge clk); chk(start_pulse == 0, "R4 latency c1", start_pulse, 0);
      @(negedge clk); chk(start_pulse == 0, "R4 latency c2", start_pulse, 0);
      @(negedge clk); chk(start_pulse == 1, "R4 latency c3", start_pulse, 1);
      @(negedge clk); chk(start_pulse == 0, "R4 one cycle", start_pulse, 0);
      ev_in = 0; idle(5);

      // R3 R4 R5 R6 all modes, both directions, line 6
      for (int p = 0; p < 4; p++) begin
         edge_trial(1, p, 6, 1, 16'h0, $sformatf("R3/R4/R5/R6 mode%0d rise", p));
         edge_trial(1, p, 6, 0, 16'h0, $sformatf("R3/R4/R5/R6 mode%0d fall", p));
      end

      // R7 every source code; others toggling do nothing
      for (int s = 0; s < 16; s++) begin
         edge_trial(1, 3, s, 0, 16'hFFFF ^ (16'h1 << s), $sformatf("R7 others src%0d", s));
         edge_trial(1, 1, s, 1, ev_in, $sformatf("R7 select src%0d", s));
         ev_in = 0; idle(4);
      end

      // R9 disabled
      edge_trial(0, 3, 9, 1, 16'h0, "R9 disabled rise");
      edge_trial(0, 3, 9, 0, 16'h0, "R9 disabled fall");

      // R8 source switch between opposite levels
      ev_in = 16'h0008;
      wr(cw(0, 3, 5, 1)); idle(5); pcnt = 0;
      wr(cw(0, 3, 3, 1)); idle(6);
      chk(pcnt == 0, "R8 switch to high line", pcnt, 0);
      wr(cw(0, 3, 5, 1)); idle(6);
      chk(pcnt == 0, "R8 switch to low line", pcnt, 0);
      ev_in = 0; idle(5);

      // R10 software start while disabled
      pcnt = 0;
      wr(cw(1, 0, 0, 0)); idle(5);
      rd(8'h08, v); chk(v[30] == 0, "R10 bit reads 0", v[30], 0);
      chk(pcnt == 0, "R10 no pulse", pcnt, 0);

      // R11 software start, hold until ack
      pcnt = 0;
      wr(cw(1, 0, 0, 1)); idle(6);
      chk(pcnt == 1, "R11 one pulse", pcnt, 1);
      rd(8'h08, v); chk(v[30] == 1, "R11 held before ack", v[30], 1);
      @(negedge clk); start_ack = 1; #1 chk(bus_rdata[30] == 1, "R11 still set in ack cycle", bus_rdata[30], 1);
      @(negedge clk); start_ack = 0; #1 chk(bus_rdata[30] == 0, "R11 cleared after ack", bus_rdata[30], 0);
      idle(4); chk(pcnt == 1, "R11 no extra pulse", pcnt, 1);

      // R10 disable drops pending request
      wr(cw(1, 0, 0, 1)); idle(3);
      wr(cw(0, 0, 0, 0));
      rd(8'h08, v); chk(v[30] == 0, "R10 disable drops request", v[30], 0);

      // R12 merge: edge and software request same cycle
      wr(cw(0, 1, 4, 1)); idle(5); pcnt = 0;
      @(negedge clk); ev_in[4] = 1;
      wr(cw(1, 1, 4, 1));
      idle(6);
      chk(pcnt == 1, "R12 merged pulse", pcnt, 1);
      @(negedge clk); start_ack = 1;
      @(negedge clk); start_ack = 0;
      ev_in = 0; idle(5);

      // random trials, R3..R7, R9
      for (int t = 0; t < 120; t++) begin
         bit re = ($urandom % 4) != 0;
         int rp = $urandom % 4;
         int rs = $urandom % 16;
         edge_trial(re, rp, rs, 1'($urandom), 16'($urandom),
                    $sformatf("R4/R5/R6/R7/R9 rand t%0d", t));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule